// File: doc/BRIEF.md
# Directory Coherence Controller

This block is the home-node engine of a directory-based coherence scheme. For every memory block it keeps a record with one presence flag per processor and a dirty flag. Processors send it read requests and write-ownership requests. It answers reads of clean blocks straight from its local data array. Before it grants ownership, it sends invalidation probes only to the processors that are recorded as holding a copy, and it waits for an acknowledgement from each of them. When a block is held dirty, the single recorded owner is asked for its copy. That copy is written back into the data array before the reply leaves.

All processors share one request port, one write-back port and one reply port. Each processor has its own invalidate, fetch and acknowledge wires, so a probe reaches only the processor it names. The engine works on one transaction at a time and keeps `req_ready` low until that transaction has replied. The interconnect, the caches and the memory timing are not part of the block. The data array is a register bank that starts from a computed pattern.

Top module: `dir_coh_ctrl`

## Requirements
- R1: After reset every directory record is empty and clean. `req_ready` is 1 and `rsp_valid`, `inv_valid` and `fetch_valid` are all 0. Data word b of the array starts at (b+1)*17.
- R2: A read of a block that is not dirty replies one cycle after acceptance, with the array's data and no probe. The requester is then recorded as present.
- R3: A write request to a clean block raises `inv_valid` for one cycle, one cycle after acceptance. Bit p of `inv_valid` belongs to processor p. The mask is exactly the set of present processors other than the requester.
- R4: A write reply follows an invalidation only one cycle after the last targeted acknowledgement. Acknowledgements from processors that were not targeted have no effect.
- R5: After a write completes, the writer is the only processor present and the block is dirty.
- R6: A request to a block held dirty by another processor raises `fetch_valid` one-hot on the owner for one cycle. The reply comes one cycle after a write-back from that owner and carries the written-back data. Write-backs from other processors are ignored.
- R7: A read of a dirty block stores the owner's data in the array and clears the dirty flag. Both the former owner and the reader are then recorded as present.
- R8: From acceptance until its reply, `req_ready` stays 0 and further requests are held. `rsp_valid` is a single-cycle pulse, and `req_ready` returns to 1 the cycle after it.
- R9: A write by a processor that is the only present holder, or by the dirty owner, or a write to an uncached block, replies one cycle after acceptance with no probe.
- R10: A reply carries the requester's id in `rsp_dst`, the request kind in `rsp_write` (1 = write) and the block index in `rsp_blk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request taken on this edge |
| req_src | input | PID_W | Requesting processor id |
| req_write | input | 1 | 1 = write-ownership, 0 = read |
| req_blk | input | BLK_W | Block index |
| inv_valid | output | N_PROC | Per-processor invalidate strobe |
| ack_valid | input | N_PROC | Per-processor invalidate acknowledgement |
| fetch_valid | output | N_PROC | Per-processor fetch strobe to the dirty owner |
| probe_blk | output | BLK_W | Block addressed by invalidate or fetch |
| wb_valid | input | 1 | Write-back data present |
| wb_src | input | PID_W | Processor supplying the write-back |
| wb_data | input | DATA_W | Written-back block data |
| rsp_valid | output | 1 | Reply strobe |
| rsp_dst | output | PID_W | Processor the reply is for |
| rsp_write | output | 1 | Reply answers a write request |
| rsp_blk | output | BLK_W | Block index of the reply |
| rsp_data | output | DATA_W | Block data |

## Verification
The hardest state to reach is a block that is clean but shared by a former dirty owner and a later reader. The only way to see that state is through the probe mask of a third processor's write. The bench builds it in a fixed order: a read, then a competing write that invalidates two sharers, then a read that forces a fetch and a write-back. A further write then has to target exactly those two processors. Acknowledgements and write-backs from the wrong processors are inserted during the waiting phases, to show that they neither release the reply nor corrupt the data.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_WB    = 3'd2,
    ST_INV   = 3'd3,
    ST_ACK   = 3'd4,
    ST_RESP  = 3'd5
  } eng_state_t;

  localparam int unsigned INIT_STEP = 17;

endpackage

// File: rtl/dcc_rst_sync.sv
module dcc_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_n_out = hold_q;

endmodule

// File: rtl/dcc_dir_store.sv
module dcc_dir_store #(
  parameter int N_PROC = 4,
  parameter int N_BLK  = 8,
  localparam int BLK_W = $clog2(N_BLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BLK_W-1:0]  rd_blk,
  output logic [N_PROC-1:0] rd_pres,
  output logic              rd_dirty,
  input  logic              wr_en,
  input  logic [BLK_W-1:0]  wr_blk,
  input  logic [N_PROC-1:0] wr_pres,
  input  logic              wr_dirty
);

  logic [N_PROC-1:0] pres_q  [N_BLK];
  logic              dirty_q [N_BLK];

  for (genvar b = 0; b < N_BLK; b++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_blk == BLK_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pres_q[b]  <= '0;
        dirty_q[b] <= 1'b0;
      end else if (hit) begin
        pres_q[b]  <= wr_pres;
        dirty_q[b] <= wr_dirty;
      end
    end
  end

  assign rd_pres  = pres_q[rd_blk];
  assign rd_dirty = dirty_q[rd_blk];

endmodule

// File: rtl/dcc_mem_store.sv
module dcc_mem_store #(
  parameter int N_BLK  = 8,
  parameter int DATA_W = 16,
  localparam int BLK_W = $clog2(N_BLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BLK_W-1:0]  rd_blk,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [BLK_W-1:0]  wr_blk,
  input  logic [DATA_W-1:0] wr_data
);

  import dcc_pkg::*;

  logic [DATA_W-1:0] word_q [N_BLK];

  for (genvar b = 0; b < N_BLK; b++) begin : g_word
    localparam logic [DATA_W-1:0] INIT_VAL = DATA_W'((b + 1) * INIT_STEP);
    logic hit;
    assign hit = wr_en && (wr_blk == BLK_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[b] <= INIT_VAL;
      end else if (hit) begin
        word_q[b] <= wr_data;
      end
    end
  end

  assign rd_data = word_q[rd_blk];

endmodule

// File: rtl/dcc_engine.sv
module dcc_engine #(
  parameter int N_PROC = 4,
  parameter int N_BLK  = 8,
  parameter int DATA_W = 16,
  localparam int PID_W = $clog2(N_PROC),
  localparam int BLK_W = $clog2(N_BLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [PID_W-1:0]  req_src,
  input  logic              req_write,
  input  logic [BLK_W-1:0]  req_blk,
  output logic              req_ready,
  input  logic [N_PROC-1:0] dir_rd_pres,
  input  logic              dir_rd_dirty,
  output logic              dir_wr_en,
  output logic [BLK_W-1:0]  dir_wr_blk,
  output logic [N_PROC-1:0] dir_wr_pres,
  output logic              dir_wr_dirty,
  output logic [BLK_W-1:0]  mem_rd_blk,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_en,
  output logic [BLK_W-1:0]  mem_wr_blk,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic [N_PROC-1:0] inv_valid,
  input  logic [N_PROC-1:0] ack_valid,
  output logic [N_PROC-1:0] fetch_valid,
  output logic [BLK_W-1:0]  probe_blk,
  input  logic              wb_valid,
  input  logic [PID_W-1:0]  wb_src,
  input  logic [DATA_W-1:0] wb_data,
  output logic              rsp_valid,
  output logic [PID_W-1:0]  rsp_dst,
  output logic              rsp_write,
  output logic [BLK_W-1:0]  rsp_blk,
  output logic [DATA_W-1:0] rsp_data
);

  import dcc_pkg::*;

  eng_state_t        state_q, state_n;
  logic [PID_W-1:0]  src_q;
  logic              write_q;
  logic [BLK_W-1:0]  blk_q;
  logic [N_PROC-1:0] pres_q;
  logic              dirty_q;
  logic [N_PROC-1:0] pend_q, pend_n;
  logic              pend_en;
  logic              load_en;

  logic [N_PROC-1:0] req_bit;
  logic [N_PROC-1:0] src_bit;
  logic [N_PROC-1:0] others;
  logic              req_is_owner;
  logic              wb_hit;
  logic [N_PROC-1:0] ack_left;

  assign req_bit      = N_PROC'(1) << req_src;
  assign src_bit      = N_PROC'(1) << src_q;
  assign others       = dir_rd_pres & ~req_bit;
  assign req_is_owner = (dir_rd_pres & req_bit) != '0;
  assign wb_hit       = wb_valid && pres_q[wb_src];
  assign ack_left     = pend_q & ~ack_valid;

  // next-state process
  always_comb begin
    state_n = state_q;
    pend_n  = pend_q;
    pend_en = 1'b0;
    load_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          load_en = 1'b1;
          pend_en = 1'b1;
          pend_n  = others;
          if (dir_rd_dirty && !req_is_owner) begin
            state_n = ST_FETCH;
          end else if (req_write && (others != '0)) begin
            state_n = ST_INV;
          end else begin
            state_n = ST_RESP;
          end
        end
      end
      ST_FETCH: state_n = ST_WB;
      ST_WB: begin
        if (wb_hit) begin
          state_n = ST_RESP;
        end
      end
      ST_INV: state_n = ST_ACK;
      ST_ACK: begin
        pend_en = 1'b1;
        pend_n  = ack_left;
        if (ack_left == '0) begin
          state_n = ST_RESP;
        end
      end
      ST_RESP: state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      write_q <= 1'b0;
      blk_q   <= '0;
      pres_q  <= '0;
      dirty_q <= 1'b0;
    end else if (load_en) begin
      src_q   <= req_src;
      write_q <= req_write;
      blk_q   <= req_blk;
      pres_q  <= dir_rd_pres;
      dirty_q <= dir_rd_dirty;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_en) begin
      pend_q <= pend_n;
    end
  end

  // directory update at reply time
  logic keep_dirty;
  assign keep_dirty   = dirty_q && ((pres_q & src_bit) != '0);
  assign dir_wr_en    = (state_q == ST_RESP);
  assign dir_wr_blk   = blk_q;
  assign dir_wr_pres  = write_q ? src_bit : (pres_q | src_bit);
  assign dir_wr_dirty = write_q | keep_dirty;

  // data array
  assign mem_rd_blk  = blk_q;
  assign mem_wr_en   = (state_q == ST_WB) && wb_hit;
  assign mem_wr_blk  = blk_q;
  assign mem_wr_data = wb_data;

  // outputs
  assign req_ready   = (state_q == ST_IDLE);
  assign inv_valid   = (state_q == ST_INV)   ? pend_q : '0;
  assign fetch_valid = (state_q == ST_FETCH) ? pres_q : '0;
  assign probe_blk   = blk_q;
  assign rsp_valid   = (state_q == ST_RESP);
  assign rsp_dst     = src_q;
  assign rsp_write   = write_q;
  assign rsp_blk     = blk_q;
  assign rsp_data    = mem_rd_data;

endmodule

// File: rtl/dir_coh_ctrl.sv
module dir_coh_ctrl #(
  parameter int N_PROC = 4,
  parameter int N_BLK  = 8,
  parameter int DATA_W = 16,
  localparam int PID_W = $clog2(N_PROC),
  localparam int BLK_W = $clog2(N_BLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PID_W-1:0]  req_src,
  input  logic              req_write,
  input  logic [BLK_W-1:0]  req_blk,
  output logic [N_PROC-1:0] inv_valid,
  input  logic [N_PROC-1:0] ack_valid,
  output logic [N_PROC-1:0] fetch_valid,
  output logic [BLK_W-1:0]  probe_blk,
  input  logic              wb_valid,
  input  logic [PID_W-1:0]  wb_src,
  input  logic [DATA_W-1:0] wb_data,
  output logic              rsp_valid,
  output logic [PID_W-1:0]  rsp_dst,
  output logic              rsp_write,
  output logic [BLK_W-1:0]  rsp_blk,
  output logic [DATA_W-1:0] rsp_data
);

  logic              rst_sync_n;
  logic              eng_ready;
  logic [N_PROC-1:0] dir_rd_pres;
  logic              dir_rd_dirty;
  logic              dir_wr_en;
  logic [BLK_W-1:0]  dir_wr_blk;
  logic [N_PROC-1:0] dir_wr_pres;
  logic              dir_wr_dirty;
  logic [BLK_W-1:0]  mem_rd_blk;
  logic [DATA_W-1:0] mem_rd_data;
  logic              mem_wr_en;
  logic [BLK_W-1:0]  mem_wr_blk;
  logic [DATA_W-1:0] mem_wr_data;
  logic              req_take;

  dcc_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  dcc_dir_store #(.N_PROC(N_PROC), .N_BLK(N_BLK)) u_dir (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_blk   (req_blk),
    .rd_pres  (dir_rd_pres),
    .rd_dirty (dir_rd_dirty),
    .wr_en    (dir_wr_en),
    .wr_blk   (dir_wr_blk),
    .wr_pres  (dir_wr_pres),
    .wr_dirty (dir_wr_dirty)
  );

  dcc_mem_store #(.N_BLK(N_BLK), .DATA_W(DATA_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_blk  (mem_rd_blk),
    .rd_data (mem_rd_data),
    .wr_en   (mem_wr_en),
    .wr_blk  (mem_wr_blk),
    .wr_data (mem_wr_data)
  );

  assign req_take = req_valid & rst_sync_n;

  dcc_engine #(.N_PROC(N_PROC), .N_BLK(N_BLK), .DATA_W(DATA_W)) u_eng (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .req_valid    (req_take),
    .req_src      (req_src),
    .req_write    (req_write),
    .req_blk      (req_blk),
    .req_ready    (eng_ready),
    .dir_rd_pres  (dir_rd_pres),
    .dir_rd_dirty (dir_rd_dirty),
    .dir_wr_en    (dir_wr_en),
    .dir_wr_blk   (dir_wr_blk),
    .dir_wr_pres  (dir_wr_pres),
    .dir_wr_dirty (dir_wr_dirty),
    .mem_rd_blk   (mem_rd_blk),
    .mem_rd_data  (mem_rd_data),
    .mem_wr_en    (mem_wr_en),
    .mem_wr_blk   (mem_wr_blk),
    .mem_wr_data  (mem_wr_data),
    .inv_valid    (inv_valid),
    .ack_valid    (ack_valid),
    .fetch_valid  (fetch_valid),
    .probe_blk    (probe_blk),
    .wb_valid     (wb_valid),
    .wb_src       (wb_src),
    .wb_data      (wb_data),
    .rsp_valid    (rsp_valid),
    .rsp_dst      (rsp_dst),
    .rsp_write    (rsp_write),
    .rsp_blk      (rsp_blk),
    .rsp_data     (rsp_data)
  );

  assign req_ready = eng_ready & rst_sync_n;

endmodule

// File: rtl/dcc_checker.sv
module dcc_checker #(
  parameter int N_PROC = 4,
  parameter int N_BLK  = 8,
  localparam int PID_W = $clog2(N_PROC),
  localparam int BLK_W = $clog2(N_BLK)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [PID_W-1:0]  req_src,
  input logic [BLK_W-1:0]  req_blk,
  input logic [N_PROC-1:0] inv_valid,
  input logic [N_PROC-1:0] fetch_valid,
  input logic              rsp_valid,
  input logic [PID_W-1:0]  rsp_dst,
  input logic [BLK_W-1:0]  rsp_blk
);

  logic [PID_W-1:0] cap_src;
  logic [BLK_W-1:0] cap_blk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_src <= '0;
      cap_blk <= '0;
    end else if (req_valid && req_ready) begin
      cap_src <= req_src;
      cap_blk <= req_blk;
    end
  end

  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);                        // R8
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);                                       // R8
  AST_RSP_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);                                       // R8
  AST_FETCH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fetch_valid));                                          // R6
  AST_PROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !((|inv_valid) && (|fetch_valid)));                              // R3
  AST_INV_NOT_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    (|inv_valid) |-> !inv_valid[cap_src]);                           // R3
  AST_INV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|inv_valid) |=> (inv_valid == '0));                             // R3
  AST_RSP_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_dst == cap_src && rsp_blk == cap_blk));       // R10

endmodule

bind dir_coh_ctrl dcc_checker #(.N_PROC(N_PROC), .N_BLK(N_BLK)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_src     (req_src),
  .req_blk     (req_blk),
  .inv_valid   (inv_valid),
  .fetch_valid (fetch_valid),
  .rsp_valid   (rsp_valid),
  .rsp_dst     (rsp_dst),
  .rsp_blk     (rsp_blk)
);

// File: tb/dir_coh_ctrl_tb_top.sv
module dir_coh_ctrl_tb_top;

  localparam int NP = 4;
  localparam int NB = 8;
  localparam int DW = 16;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [1:0]    req_src;
  logic          req_write;
  logic [2:0]    req_blk;
  logic [NP-1:0] inv_valid;
  logic [NP-1:0] ack_valid;
  logic [NP-1:0] fetch_valid;
  logic [2:0]    probe_blk;
  logic          wb_valid;
  logic [1:0]    wb_src;
  logic [DW-1:0] wb_data;
  logic          rsp_valid;
  logic [1:0]    rsp_dst;
  logic          rsp_write;
  logic [2:0]    rsp_blk;
  logic [DW-1:0] rsp_data;

  int n_checks = 0;
  int n_err    = 0;

  dir_coh_ctrl #(.N_PROC(NP), .N_BLK(NB), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src),
    .req_write(req_write), .req_blk(req_blk),
    .inv_valid(inv_valid), .ack_valid(ack_valid),
    .fetch_valid(fetch_valid), .probe_blk(probe_blk),
    .wb_valid(wb_valid), .wb_src(wb_src), .wb_data(wb_data),
    .rsp_valid(rsp_valid), .rsp_dst(rsp_dst), .rsp_write(rsp_write),
    .rsp_blk(rsp_blk), .rsp_data(rsp_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [DW-1:0] init_word(input int b);
    return DW'((b + 1) * 17);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  // returns at the falling edge after the accepting rising edge
  task automatic issue(input int src, input bit wr, input int blk);
    @(negedge clk);
    check("R8 ready before issue", 32'(req_ready), 32'd1);
    req_valid = 1'b1;
    req_src   = 2'(src);
    req_write = wr;
    req_blk   = 3'(blk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse_ack(input logic [NP-1:0] m);
    ack_valid = m;
    @(negedge clk);
    ack_valid = '0;
  endtask

  task automatic pulse_wb(input int src, input logic [DW-1:0] d);
    wb_valid = 1'b1;
    wb_src   = 2'(src);
    wb_data  = d;
    @(negedge clk);
    wb_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string tag, input int dst, input bit wr,
                            input int blk, input logic [DW-1:0] d);
    check({tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    check({tag, " rsp_data"},  32'(rsp_data),  32'(d));
    check("R10 rsp_dst",       32'(rsp_dst),   32'(dst));
    check("R10 rsp_write",     32'(rsp_write), 32'(wr));
    check("R10 rsp_blk",       32'(rsp_blk),   32'(blk));
    @(negedge clk);
    check("R8 rsp pulse ends", 32'(rsp_valid), 32'd0);
    check("R8 ready returns",  32'(req_ready), 32'd1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_src = '0; req_write = 1'b0; req_blk = '0;
    ack_valid = '0; wb_valid = 1'b0; wb_src = '0; wb_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 ready",  32'(req_ready),   32'd1);
    check("R1 rsp",    32'(rsp_valid),   32'd0);
    check("R1 inv",    32'(inv_valid),   32'd0);
    check("R1 fetch",  32'(fetch_valid), 32'd0);
  endtask

  task automatic t_clean_reads();
    issue(0, 1'b0, 1);
    check("R2 no inv",   32'(inv_valid),   32'd0);
    check("R2 no fetch", 32'(fetch_valid), 32'd0);
    expect_rsp("R2 read P0", 0, 1'b0, 1, init_word(1));
    issue(2, 1'b0, 1);
    expect_rsp("R2 read P2", 2, 1'b0, 1, init_word(1));
  endtask

  task automatic t_write_sharers();
    issue(1, 1'b1, 1);
    check("R3 inv mask", 32'(inv_valid), 32'h5);
    check("R3 probe blk", 32'(probe_blk), 32'd1);
    check("R4 no early rsp", 32'(rsp_valid), 32'd0);
    @(negedge clk);
    check("R3 inv one cycle", 32'(inv_valid), 32'd0);
    check("R8 busy", 32'(req_ready), 32'd0);
    pulse_ack(4'b1000);
    check("R4 stray ack ignored", 32'(rsp_valid), 32'd0);
    pulse_ack(4'b0001);
    check("R4 partial acks", 32'(rsp_valid), 32'd0);
    check("R8 still busy", 32'(req_ready), 32'd0);
    pulse_ack(4'b0100);
    expect_rsp("R4 write after acks", 1, 1'b1, 1, init_word(1));
  endtask

  task automatic t_dirty_read();
    issue(3, 1'b0, 1);
    check("R6 fetch owner", 32'(fetch_valid), 32'h2);
    check("R6 no inv", 32'(inv_valid), 32'd0);
    @(negedge clk);
    check("R6 fetch one cycle", 32'(fetch_valid), 32'd0);
    pulse_wb(0, 16'h5555);
    check("R6 foreign wb ignored", 32'(rsp_valid), 32'd0);
    pulse_wb(1, 16'hBEEF);
    expect_rsp("R6 read dirty", 3, 1'b0, 1, 16'hBEEF);
  endtask

  task automatic t_after_dirty_read();
    issue(0, 1'b1, 1);
    check("R7 both present", 32'(inv_valid), 32'hA);
    check("R7 dirty cleared", 32'(fetch_valid), 32'd0);
    @(negedge clk);
    pulse_ack(4'b1010);
    expect_rsp("R7 memory written back", 0, 1'b1, 1, 16'hBEEF);
  endtask

  task automatic t_owner_write();
    issue(0, 1'b1, 1);
    check("R9 owner no inv", 32'(inv_valid), 32'd0);
    check("R9 owner no fetch", 32'(fetch_valid), 32'd0);
    expect_rsp("R9 owner write", 0, 1'b1, 1, 16'hBEEF);
  endtask

  task automatic t_sole_writer();
    issue(2, 1'b1, 1);
    check("R5 fetch only prior writer", 32'(fetch_valid), 32'h1);
    @(negedge clk);
    pulse_wb(0, 16'h1234);
    expect_rsp("R5 write takeover", 2, 1'b1, 1, 16'h1234);
    issue(3, 1'b0, 1);
    check("R5 only new writer", 32'(fetch_valid), 32'h4);
    @(negedge clk);
    pulse_wb(2, 16'h4321);
    expect_rsp("R5 read back", 3, 1'b0, 1, 16'h4321);
  endtask

  task automatic t_upgrades();
    issue(1, 1'b1, 5);
    check("R9 uncached no inv", 32'(inv_valid), 32'd0);
    expect_rsp("R9 uncached write", 1, 1'b1, 5, init_word(5));
    issue(2, 1'b0, 6);
    expect_rsp("R2 read blk6", 2, 1'b0, 6, init_word(6));
    issue(2, 1'b1, 6);
    check("R9 sole sharer no inv", 32'(inv_valid), 32'd0);
    check("R9 sole sharer no fetch", 32'(fetch_valid), 32'd0);
    expect_rsp("R9 sole sharer write", 2, 1'b1, 6, init_word(6));
  endtask

  initial begin
    t_reset();
    t_clean_reads();
    t_write_sharers();
    t_dirty_read();
    t_after_dirty_read();
    t_owner_write();
    t_sole_writer();
    t_upgrades();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

endmodule